// File: doc/BRIEF.md
# I2C Master Register Bank

This block is the byte-wide, software-facing register file of an I2C master controller. It decodes an 18-byte window and holds the master and slave address bytes, the control and mode registers, the clock divider, the interrupt mask, the transfer count and the direct line-control byte. Each register applies its own write mask. Three status registers use write-one-to-clear semantics, and each is set by pulses from the transfer engine.

A read of the extended status offset returns a coded bus state taken from a live busy input. The block holds the interrupt line. The engine raises it, and a software acknowledge through the status register lowers it. A self-clearing bit in the extended control register runs a soft reset, which restores every register except the address bytes.

The data buffer and the transfer engine sit outside the block. The block gives them push, pop, flush and start strobes, and it passes buffer read data through to the read port. Access is single-cycle: writes land on the next rising edge, and read data is combinational.

Top module: `i2cm_csr_bank`

## Requirements
- R1: After hard reset the following registers read 0: control, mode, status, transfer count, extended control, clock divider, interrupt mask, and all four address bytes. Extended status holds 0x40 and direct control holds 0x0F.
- R2: A write to offset 7 stores only the bits of wdata & 0x3D in the mode register. When wdata bit 6 is set, `dbuf_flush_o` pulses in the same cycle. Bit 2 of mode is the interrupt enable.
- R3: A write to offset 8 clears each status bit that is set in wdata & 0x0A. Bits in `sts_set_i` set status bits in the same edge, and a set wins over a clear.
- R4: When `irq_req_i` is high and mode bit 2 is set, status bit 1 and `irq_o` rise on the next edge. A status write with wdata bit 1 set while mode bit 2 is set lowers `irq_o`, unless a request arrives in the same cycle.
- R5: A write to offset 9 clears the stored extended status bits that are set in wdata & 0x8F. `ext_set_i` sets bits, and a set wins over a clear.
- R6: A read of offset 9 returns 0x50 while `bus_busy_i` is high and 0x40 while it is low.
- R7: A write to offset 14 stores wdata & 0x77 in the transfer count.
- R8: A write to offset 15 clears the extended control bits that are set in wdata & 0xF0. `xctl_set_i` sets bits. When wdata bit 0 is set, a soft reset restores every R1 value, overrides same-cycle sets, lowers `irq_o`, and leaves the address bytes unchanged.
- R9: Reads of offsets 1, 2, 3 and 17, and of any offset of 18 or above, return 0. Writes to those offsets change no register.
- R10: A read of offset 0 returns `dbuf_rdata_i` and pulses `dbuf_pop_o`. No other read pulses `dbuf_pop_o` or changes any register. rdata is 0 when `rd_en` is low.
- R11: A write to offset 0 pulses `dbuf_push_o` with `dbuf_wdata_o` equal to wdata. A write to offset 6 stores wdata & 0xFE in control, and it pulses `xfer_go_o` when wdata bit 0 is set.
- R12: The following offsets store wdata as written and read it back: 4 and 5 (master address low/high), 10 and 11 (slave address low/high), 12 (clock divider), and 13 (interrupt mask). Offset 16 stores and reads back wdata & 0x0F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW | Byte offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| bus_busy_i | input | 1 | Live bus busy state |
| dbuf_rdata_i | input | 8 | Head byte of external data buffer |
| dbuf_push_o | output | 1 | Buffer write strobe |
| dbuf_wdata_o | output | 8 | Byte to push |
| dbuf_pop_o | output | 1 | Buffer read strobe |
| dbuf_flush_o | output | 1 | Buffer flush strobe |
| xfer_go_o | output | 1 | Transfer start strobe |
| irq_req_i | input | 1 | Engine interrupt request |
| sts_set_i | input | 8 | Status set pulses |
| ext_set_i | input | 8 | Extended status set pulses |
| xctl_set_i | input | 8 | Extended control set pulses |
| irq_o | output | 1 | Interrupt line |
| ctl_o | output | 8 | Control register |
| mode_o | output | 8 | Mode register |
| sts_o | output | 8 | Status register |
| ext_sts_o | output | 8 | Stored extended status |
| xctl_o | output | 8 | Extended control register |
| clkdiv_o | output | 8 | Clock divider |
| imask_o | output | 8 | Interrupt mask |
| xcnt_o | output | 8 | Transfer count |
| dctl_o | output | 8 | Direct line-control register |
| madr_o | output | 16 | Master address, high:low |
| saddr_o | output | 16 | Slave address, high:low |

## Verification
The assertions assume a single access port. At most one offset is decoded per cycle, so a soft reset can never meet a write to a configuration register in the same edge. The assertions also assume the engine's set pulses may arrive in any cycle, including during a software clear of the same bit. The random stimulus keeps to this by driving one address per cycle. It applies set pulses only sparsely and at random, so clears are observable, and it also lets them collide with clears. The address range extends past the 18-byte window so that the out-of-window offsets are exercised.

// File: rtl/i2cm_csr_pkg.sv
package i2cm_csr_pkg;
  localparam int DW  = 8;
  localparam int WIN = 18;

  localparam int OFS_DBUF = 0;
  localparam int OFS_MALO = 4;
  localparam int OFS_MAHI = 5;
  localparam int OFS_CTL  = 6;
  localparam int OFS_MODE = 7;
  localparam int OFS_STS  = 8;
  localparam int OFS_EXT  = 9;
  localparam int OFS_SALO = 10;
  localparam int OFS_SAHI = 11;
  localparam int OFS_CDIV = 12;
  localparam int OFS_IMSK = 13;
  localparam int OFS_XCNT = 14;
  localparam int OFS_XCTL = 15;
  localparam int OFS_DCTL = 16;

  localparam logic [DW-1:0] CTL_MASK  = 8'hFE;
  localparam logic [DW-1:0] MODE_MASK = 8'h3D;
  localparam logic [DW-1:0] STS_W1C   = 8'h0A;
  localparam logic [DW-1:0] EXT_W1C   = 8'h8F;
  localparam logic [DW-1:0] XCNT_MASK = 8'h77;
  localparam logic [DW-1:0] XCTL_W1C  = 8'hF0;
  localparam logic [DW-1:0] DCTL_MASK = 8'h0F;
  localparam logic [DW-1:0] DCTL_RST  = 8'h0F;
  localparam logic [DW-1:0] BUS_FREE  = 8'h40;
  localparam logic [DW-1:0] BUS_BUSY  = 8'h50;

  localparam int CTL_GO     = 0;
  localparam int MODE_IEN   = 2;
  localparam int MODE_FLUSH = 6;
  localparam int STS_IRQ    = 1;
  localparam int XCTL_SRST  = 0;

  // clear-on-one under a mask, then OR in hardware sets (sets dominate)
  function automatic logic [DW-1:0] w1c_next(input logic [DW-1:0] cur,
                                             input logic wr,
                                             input logic [DW-1:0] val,
                                             input logic [DW-1:0] msk,
                                             input logic [DW-1:0] set);
    logic [DW-1:0] clr;
    clr = wr ? (val & msk) : '0;
    return (cur & ~clr) | set;
  endfunction

  function automatic logic [DW-1:0] bus_code(input logic busy);
    return busy ? BUS_BUSY : BUS_FREE;
  endfunction
endpackage

// File: rtl/i2cm_csr_decode.sv
module i2cm_csr_decode #(
  parameter int AW  = 5,
  parameter int WIN = 18
) (
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  output logic [WIN-1:0] wr_sel
);
  generate
    for (genvar i = 0; i < WIN; i++) begin : g_sel
      assign wr_sel[i] = wr_en && (addr == AW'(i));
    end
  endgenerate
endmodule

// File: rtl/i2cm_csr_cfg.sv
module i2cm_csr_cfg
  import i2cm_csr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          wr_ctl,
  input  logic          wr_mode,
  input  logic          wr_malo,
  input  logic          wr_mahi,
  input  logic          wr_salo,
  input  logic          wr_sahi,
  input  logic          wr_cdiv,
  input  logic          wr_imsk,
  input  logic          wr_xcnt,
  input  logic          wr_dctl,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ctl,
  output logic [DW-1:0] mode,
  output logic [DW-1:0] clkdiv,
  output logic [DW-1:0] imask,
  output logic [DW-1:0] xcnt,
  output logic [DW-1:0] dctl,
  output logic [2*DW-1:0] madr,
  output logic [2*DW-1:0] saddr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0; mode <= '0; clkdiv <= '0; imask <= '0; xcnt <= '0;
      dctl <= DCTL_RST;
    end else if (soft_rst) begin
      ctl <= '0; mode <= '0; clkdiv <= '0; imask <= '0; xcnt <= '0;
      dctl <= DCTL_RST;
    end else begin
      if (wr_ctl)  ctl    <= wdata & CTL_MASK;
      if (wr_mode) mode   <= wdata & MODE_MASK;
      if (wr_cdiv) clkdiv <= wdata;
      if (wr_imsk) imask  <= wdata;
      if (wr_xcnt) xcnt   <= wdata & XCNT_MASK;
      if (wr_dctl) dctl   <= wdata & DCTL_MASK;
    end
  end

  // address bytes: hard reset only, soft reset leaves them
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      madr  <= '0;
      saddr <= '0;
    end else begin
      if (wr_malo) madr[DW-1:0]     <= wdata;
      if (wr_mahi) madr[2*DW-1:DW]  <= wdata;
      if (wr_salo) saddr[DW-1:0]    <= wdata;
      if (wr_sahi) saddr[2*DW-1:DW] <= wdata;
    end
  end

  p_mode_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mode |=> mode == ($past(wdata) & MODE_MASK));
  p_xcnt_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_xcnt |=> xcnt == ($past(wdata) & XCNT_MASK));
  p_addr_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> $stable(madr) && $stable(saddr) && dctl == DCTL_RST);
endmodule

// File: rtl/i2cm_csr_stat.sv
module i2cm_csr_stat
  import i2cm_csr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_sts,
  input  logic          wr_ext,
  input  logic          wr_xctl,
  input  logic [DW-1:0] wdata,
  input  logic          irq_en,
  input  logic          irq_req,
  input  logic [DW-1:0] sts_set,
  input  logic [DW-1:0] ext_set,
  input  logic [DW-1:0] xctl_set,
  output logic          soft_rst,
  output logic [DW-1:0] sts,
  output logic [DW-1:0] ext_sts,
  output logic [DW-1:0] xctl,
  output logic          irq
);
  logic          irq_raise;
  logic          irq_ack;
  logic [DW-1:0] sts_hw_set;

  assign soft_rst   = wr_xctl && wdata[XCTL_SRST];
  assign irq_raise  = irq_req && irq_en;
  assign irq_ack    = wr_sts && wdata[STS_IRQ] && irq_en;
  assign sts_hw_set = sts_set | (irq_raise ? DW'(1 << STS_IRQ) : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts <= '0; ext_sts <= BUS_FREE; xctl <= '0; irq <= 1'b0;
    end else if (soft_rst) begin
      sts <= '0; ext_sts <= BUS_FREE; xctl <= '0; irq <= 1'b0;
    end else begin
      sts     <= w1c_next(sts, wr_sts, wdata, STS_W1C, sts_hw_set);
      ext_sts <= w1c_next(ext_sts, wr_ext, wdata, EXT_W1C, ext_set);
      xctl    <= w1c_next(xctl, wr_xctl, wdata, XCTL_W1C, xctl_set);
      if (irq_raise)    irq <= 1'b1;
      else if (irq_ack) irq <= 1'b0;
    end
  end

  p_irq_raise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_en && !soft_rst) |=> irq && sts[STS_IRQ]);
  p_irq_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sts && wdata[STS_IRQ] && irq_en && !irq_req) |=> !irq);
  p_sts_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sts && wdata[3] && !sts_set[3]) |=> !sts[3]);
  p_ext_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ext && wdata[7] && !ext_set[7]) |=> !ext_sts[7]);
  p_soft_rst_r8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> sts == '0 && xctl == '0 && ext_sts == BUS_FREE && !irq);
endmodule

// File: rtl/i2cm_csr_bank.sv
module i2cm_csr_bank
  import i2cm_csr_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  input  logic          bus_busy_i,
  input  logic [7:0]    dbuf_rdata_i,
  output logic          dbuf_push_o,
  output logic [7:0]    dbuf_wdata_o,
  output logic          dbuf_pop_o,
  output logic          dbuf_flush_o,
  output logic          xfer_go_o,
  input  logic          irq_req_i,
  input  logic [7:0]    sts_set_i,
  input  logic [7:0]    ext_set_i,
  input  logic [7:0]    xctl_set_i,
  output logic          irq_o,
  output logic [7:0]    ctl_o,
  output logic [7:0]    mode_o,
  output logic [7:0]    sts_o,
  output logic [7:0]    ext_sts_o,
  output logic [7:0]    xctl_o,
  output logic [7:0]    clkdiv_o,
  output logic [7:0]    imask_o,
  output logic [7:0]    xcnt_o,
  output logic [7:0]    dctl_o,
  output logic [15:0]   madr_o,
  output logic [15:0]   saddr_o
);
  logic [WIN-1:0] wr_sel;
  logic           soft_rst;
  logic           wr_unmapped;

  i2cm_csr_decode #(.AW(AW), .WIN(WIN)) u_dec (
    .wr_en(wr_en), .addr(addr), .wr_sel(wr_sel)
  );

  assign wr_unmapped = wr_sel[1] | wr_sel[2] | wr_sel[3] | wr_sel[WIN-1];

  i2cm_csr_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .wr_ctl(wr_sel[OFS_CTL]), .wr_mode(wr_sel[OFS_MODE]),
    .wr_malo(wr_sel[OFS_MALO]), .wr_mahi(wr_sel[OFS_MAHI]),
    .wr_salo(wr_sel[OFS_SALO]), .wr_sahi(wr_sel[OFS_SAHI]),
    .wr_cdiv(wr_sel[OFS_CDIV]), .wr_imsk(wr_sel[OFS_IMSK]),
    .wr_xcnt(wr_sel[OFS_XCNT]), .wr_dctl(wr_sel[OFS_DCTL]),
    .wdata(wdata),
    .ctl(ctl_o), .mode(mode_o), .clkdiv(clkdiv_o), .imask(imask_o),
    .xcnt(xcnt_o), .dctl(dctl_o), .madr(madr_o), .saddr(saddr_o)
  );

  i2cm_csr_stat u_stat (
    .clk(clk), .rst_n(rst_n),
    .wr_sts(wr_sel[OFS_STS]), .wr_ext(wr_sel[OFS_EXT]), .wr_xctl(wr_sel[OFS_XCTL]),
    .wdata(wdata), .irq_en(mode_o[MODE_IEN]), .irq_req(irq_req_i),
    .sts_set(sts_set_i), .ext_set(ext_set_i), .xctl_set(xctl_set_i),
    .soft_rst(soft_rst), .sts(sts_o), .ext_sts(ext_sts_o), .xctl(xctl_o),
    .irq(irq_o)
  );

  assign dbuf_push_o  = wr_sel[OFS_DBUF];
  assign dbuf_wdata_o = wdata;
  assign dbuf_pop_o   = rd_en && (addr == AW'(OFS_DBUF));
  assign dbuf_flush_o = wr_sel[OFS_MODE] && wdata[MODE_FLUSH];
  assign xfer_go_o    = wr_sel[OFS_CTL] && wdata[CTL_GO];

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (int'(addr))
        OFS_DBUF: rdata = dbuf_rdata_i;
        OFS_MALO: rdata = madr_o[7:0];
        OFS_MAHI: rdata = madr_o[15:8];
        OFS_CTL:  rdata = ctl_o;
        OFS_MODE: rdata = mode_o;
        OFS_STS:  rdata = sts_o;
        OFS_EXT:  rdata = bus_code(bus_busy_i);
        OFS_SALO: rdata = saddr_o[7:0];
        OFS_SAHI: rdata = saddr_o[15:8];
        OFS_CDIV: rdata = clkdiv_o;
        OFS_IMSK: rdata = imask_o;
        OFS_XCNT: rdata = xcnt_o;
        OFS_XCTL: rdata = xctl_o;
        OFS_DCTL: rdata = dctl_o;
        default:  rdata = '0;
      endcase
    end
  end

  p_bus_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == AW'(OFS_EXT)) |-> (rdata[6] && (rdata[4] == bus_busy_i)));
  p_unmapped_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_unmapped && sts_set_i == '0 && ext_set_i == '0 && xctl_set_i == '0 && !irq_req_i)
      |=> $stable(ctl_o) && $stable(mode_o) && $stable(sts_o) && $stable(madr_o)
          && $stable(xcnt_o) && $stable(dctl_o) && $stable(xctl_o));
endmodule

// File: tb/i2cm_csr_bank_bench.sv
module i2cm_csr_bank_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic wr_en = 0, rd_en = 0, bus_busy_i = 0, irq_req_i = 0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0, dbuf_rdata_i = '0, sts_set_i = '0, ext_set_i = '0, xctl_set_i = '0;
  logic [7:0] rdata, dbuf_wdata_o, ctl_o, mode_o, sts_o, ext_sts_o, xctl_o;
  logic [7:0] clkdiv_o, imask_o, xcnt_o, dctl_o;
  logic [15:0] madr_o, saddr_o;
  logic dbuf_push_o, dbuf_pop_o, dbuf_flush_o, xfer_go_o, irq_o;

  i2cm_csr_bank u_i2cm_csr_bank (.*);

  int vectors = 0, fails = 0;
  logic [7:0] m_ctl, m_mode, m_sts, m_ext, m_xctl, m_cdiv, m_imsk, m_xcnt, m_dctl;
  logic [15:0] m_madr, m_sadr;
  logic m_irq;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [4:0] a);
    if (!rd_en) return 8'h00;
    case (a)
      5'd0:  return dbuf_rdata_i;
      5'd4:  return m_madr[7:0];
      5'd5:  return m_madr[15:8];
      5'd6:  return m_ctl;
      5'd7:  return m_mode;
      5'd8:  return m_sts;
      5'd9:  return bus_busy_i ? 8'h50 : 8'h40;
      5'd10: return m_sadr[7:0];
      5'd11: return m_sadr[15:8];
      5'd12: return m_cdiv;
      5'd13: return m_imsk;
      5'd14: return m_xcnt;
      5'd15: return m_xctl;
      5'd16: return m_dctl;
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_reset(input logic hard);
    m_ctl = 0; m_mode = 0; m_sts = 0; m_ext = 8'h40; m_xctl = 0;
    m_cdiv = 0; m_imsk = 0; m_xcnt = 0; m_dctl = 8'h0F; m_irq = 0;
    if (hard) begin m_madr = 0; m_sadr = 0; end
  endtask

  task automatic model_edge();
    logic w; logic en;
    w  = wr_en;
    en = m_mode[2];
    if (w && addr == 5'd15 && wdata[0]) begin
      model_reset(1'b0);
    end else begin
      m_sts = (m_sts & ~((w && addr == 5'd8) ? (wdata & 8'h0A) : 8'h00)) | sts_set_i
              | ((irq_req_i && en) ? 8'h02 : 8'h00);
      m_ext = (m_ext & ~((w && addr == 5'd9) ? (wdata & 8'h8F) : 8'h00)) | ext_set_i;
      m_xctl = (m_xctl & ~((w && addr == 5'd15) ? (wdata & 8'hF0) : 8'h00)) | xctl_set_i;
      if (irq_req_i && en) m_irq = 1;
      else if (w && addr == 5'd8 && wdata[1] && en) m_irq = 0;
      if (w) case (addr)
        5'd4:  m_madr[7:0]  = wdata;
        5'd5:  m_madr[15:8] = wdata;
        5'd6:  m_ctl  = wdata & 8'hFE;
        5'd7:  m_mode = wdata & 8'h3D;
        5'd10: m_sadr[7:0]  = wdata;
        5'd11: m_sadr[15:8] = wdata;
        5'd12: m_cdiv = wdata;
        5'd13: m_imsk = wdata;
        5'd14: m_xcnt = wdata & 8'h77;
        5'd16: m_dctl = wdata & 8'h0F;
        default: ;
      endcase
    end
  endtask

  task automatic tick();
    #1;
    chk("R10 rdata", {8'h0, rdata}, {8'h0, exp_read(addr)});
    chk("R10 pop", {15'h0, dbuf_pop_o}, {15'h0, rd_en && addr == 5'd0});
    chk("R11 push", {15'h0, dbuf_push_o}, {15'h0, wr_en && addr == 5'd0});
    chk("R11 push data", {8'h0, dbuf_wdata_o}, {8'h0, wdata});
    chk("R2 flush", {15'h0, dbuf_flush_o}, {15'h0, wr_en && addr == 5'd7 && wdata[6]});
    chk("R11 go", {15'h0, xfer_go_o}, {15'h0, wr_en && addr == 5'd6 && wdata[0]});
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk("R11 ctl", {8'h0, ctl_o}, {8'h0, m_ctl});
    chk("R2 mode", {8'h0, mode_o}, {8'h0, m_mode});
    chk("R3 sts", {8'h0, sts_o}, {8'h0, m_sts});
    chk("R5 ext", {8'h0, ext_sts_o}, {8'h0, m_ext});
    chk("R8 xctl", {8'h0, xctl_o}, {8'h0, m_xctl});
    chk("R12 clkdiv", {8'h0, clkdiv_o}, {8'h0, m_cdiv});
    chk("R12 imask", {8'h0, imask_o}, {8'h0, m_imsk});
    chk("R7 xcnt", {8'h0, xcnt_o}, {8'h0, m_xcnt});
    chk("R12 dctl", {8'h0, dctl_o}, {8'h0, m_dctl});
    chk("R12 madr", madr_o, m_madr);
    chk("R12 saddr", saddr_o, m_sadr);
    chk("R4 irq", {15'h0, irq_o}, {15'h0, m_irq});
  endtask

  task automatic idle();
    wr_en = 0; rd_en = 0; irq_req_i = 0;
    sts_set_i = 0; ext_set_i = 0; xctl_set_i = 0;
  endtask

  task automatic acc(input logic w, input logic r, input logic [4:0] a, input logic [7:0] d);
    idle();
    wr_en = w; rd_en = r; addr = a; wdata = d;
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    model_reset(1'b1);
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 ctl", {8'h0, ctl_o}, 16'h0);
    chk("R1 ext", {8'h0, ext_sts_o}, 16'h0040);
    chk("R1 dctl", {8'h0, dctl_o}, 16'h000F);
    chk("R1 madr", madr_o, 16'h0);
    chk("R1 irq", {15'h0, irq_o}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);

    acc(1, 0, 5'd4, 8'h5A);                       // R12
    acc(0, 1, 5'd4, 8'h00);
    chk("R12 madr lo", madr_o, 16'h005A);
    acc(1, 0, 5'd7, 8'hFF);                       // R2
    chk("R2 masked mode", {8'h0, mode_o}, 16'h003D);
    acc(1, 0, 5'd6, 8'h37);                       // R11
    chk("R11 ctl literal", {8'h0, ctl_o}, 16'h0036);
    acc(1, 0, 5'd0, 8'hA5);
    dbuf_rdata_i = 8'h3C;
    acc(0, 1, 5'd0, 8'h00);                       // R10
    bus_busy_i = 1; acc(0, 1, 5'd9, 8'h00);       // R6
    bus_busy_i = 0; acc(0, 1, 5'd9, 8'h00);
    acc(0, 1, 5'd1, 8'h00);                       // R9
    acc(0, 1, 5'd17, 8'h00);
    acc(0, 1, 5'd20, 8'h00);
    acc(1, 0, 5'd2, 8'hFF);
    acc(1, 0, 5'd17, 8'hFF);
    acc(1, 0, 5'd14, 8'hFF);                      // R7
    chk("R7 xcnt literal", {8'h0, xcnt_o}, 16'h0077);
    idle(); irq_req_i = 1; tick();                // R4
    chk("R4 irq raised", {15'h0, irq_o}, 16'h1);
    acc(1, 0, 5'd8, 8'h02);
    chk("R4 irq acked", {15'h0, irq_o}, 16'h0);
    idle(); sts_set_i = 8'hFF; tick();            // R3
    acc(1, 0, 5'd8, 8'hFF);
    chk("R3 sts literal", {8'h0, sts_o}, 16'h00F5);
    idle(); ext_set_i = 8'h3F; tick();            // R5
    acc(1, 0, 5'd9, 8'hFF);
    chk("R5 ext literal", {8'h0, ext_sts_o}, 16'h0070);
    idle(); xctl_set_i = 8'hFF; tick();           // R8
    acc(1, 0, 5'd15, 8'h30);
    chk("R8 xctl literal", {8'h0, xctl_o}, 16'h00CF);
    idle(); irq_req_i = 1; tick();
    acc(1, 0, 5'd15, 8'h01);
    chk("R8 soft keeps madr", madr_o, 16'h005A);
    chk("R8 soft dctl", {8'h0, dctl_o}, 16'h000F);
    chk("R8 soft irq", {15'h0, irq_o}, 16'h0);

    for (int i = 0; i < 4000; i++) begin
      idle();
      addr  = 5'($urandom % 32);
      wr_en = ($urandom % 2) == 0;
      rd_en = !wr_en && (($urandom % 2) == 0);
      wdata = 8'($urandom);
      if (addr == 5'd15 && ($urandom % 4) != 0) wdata[0] = 1'b0;
      dbuf_rdata_i = 8'($urandom);
      bus_busy_i   = ($urandom % 2) == 0;
      irq_req_i    = ($urandom % 8) == 0;
      if (($urandom % 8) == 0) sts_set_i  = 8'($urandom);
      if (($urandom % 8) == 0) ext_set_i  = 8'($urandom);
      if (($urandom % 8) == 0) xctl_set_i = 8'($urandom);
      tick();
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule